// File: doc/BRIEF.md
# Serial Transmitter with Queued Line Pulse

This block is an asynchronous serial transmitter. Each word goes through a holding register and then a shift register. A word written while the shifter is free moves on at once. A word written while a frame is on the line waits in the holding register, and the engine sends it straight after the current stop period with no idle gap. A frame is a low start bit, then the data bits with bit 0 first, then an optional address bit, an optional parity bit, and one or two high stop bits. An external enable, `tick`, sets the bit rate. One bit-time is the interval between two ticks, and every change on the serial line happens at a tick.

A separate command register queues a line pulse. The pulse has a programmable length in bit-times and a chosen level. It starts only after every frame that was queued before the command has sent its last stop bit. Its main use is a bus break of 13 or more bit-times, made without changing the bit rate and without software timing. A control bit inverts the pulse level. The command is honoured only in the standard mode.

State machine states: `S_IDLE` (line high, nothing to send), `S_ARMED` (word moved into the shifter, waiting for the next tick), `S_START`, `S_DATA`, `S_ADDR`, `S_PARITY`, `S_STOP` and `S_PULSE`. The transitions are:
- `S_IDLE→S_ARMED` when an eligible word is waiting.
- `S_IDLE→S_PULSE` on a tick when a pulse is pending.
- `S_ARMED→S_START` on a tick.
- `S_START→S_DATA` on a tick.
- `S_DATA→S_ADDR`, `S_DATA→S_PARITY` or `S_DATA→S_STOP` after the last data bit.
- `S_ADDR→S_PARITY` or `S_ADDR→S_STOP`.
- `S_PARITY→S_STOP`.
- `S_STOP→S_START` when a word follows, `S_STOP→S_PULSE` when a pulse is pending, otherwise `S_STOP→S_IDLE`.
- `S_PULSE→S_START` when a word waits, otherwise `S_PULSE→S_IDLE`.

Top module: `uart_pulse_tx`

## Requirements
- R1: A data write (`wr_sel`=0) into an empty holding register is moved into the shifter within two clocks, so `hold_empty` is high again. A word written while a frame is on the line waits in the holding register and is sent directly after the current frame, with no idle bit in between.
- R2: A frame is one start bit at 0, then the 8 data bits with bit 0 first, then the stop bits at 1. There is one stop bit, or two when control bit 2 is set. The line changes only in the clock after a tick.
- R3: Control bit 0 enables a parity bit after the data bits. Control bit 1 selects odd parity. With even parity, the data bits plus the parity bit hold an even number of ones.
- R4: Control bit 3 adds an address bit after the data bits, before parity. Its value is control bit 4. The address bit is included in the parity calculation.
- R5: A pulse command write (`wr_sel`=1) gives the pulse length in bit-times in bits [6:0] and the level in bit 7: 0 gives a low pulse, 1 holds the line high. The command value 0x0D gives a low pulse of 13 bit-times.
- R6: The pulse begins right after the last stop bit of every word queued before the command, including a word waiting in the holding register.
- R7: Control bit 7 inverts the pulse level, so command 0x83 gives a low pulse of 3 bit-times.
- R8: When control bits [6:5] are not 00, a pulse command is ignored: `tx_idle` stays high and the line stays high.
- R9: A pulse command of length 0 has no effect, and `tx_idle` stays high.
- R10: A word written after a pulse command has been accepted waits until the pulse ends. It then starts with no idle bit.
- R11: `tx_idle` goes low in the clock after a pulse command is accepted and stays low until the last pulse bit-time ends. A pulse command written while a pulse is pending or active is ignored.
- R12: After reset, `txd`, `hold_empty` and `tx_idle` are all 1. `tx_idle` is high only while the line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Bit-rate enable, one clock per bit-time |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target register: 0 data, 1 pulse command, 2 control |
| wr_data | input | DATA_W | Write value |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register is empty |
| tx_idle | output | 1 | No word held or shifting, no pulse pending or active |

## Verification
The bench logs the line once per bit-time. It then compares whole streams bit by bit, so a design that leaves an idle bit between queued frames, or between a pulse and the word that follows it, fails on position. One test queues a word in the holding register before the break command. A design that started the pulse as soon as the shifter drained would cut that word off. Another test writes a word while the pulse is pending; a design that let it overtake the pulse would show its start bit early. Further tests cover the address bit inside the parity, the inverted pulse level, commands ignored in the wrong mode or with length zero, and a second command written during an active pulse, which would otherwise lengthen the break.

// File: rtl/uptx_pkg.sv
package uptx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_START,
        S_DATA,
        S_ADDR,
        S_PARITY,
        S_STOP,
        S_PULSE
    } tx_state_t;

    // Control register layout, bit 7 down to bit 0
    typedef struct packed {
        logic       pulse_inv;  // 7
        logic [1:0] mode;       // 6:5
        logic       addr_val;   // 4
        logic       addr_en;    // 3
        logic       two_stop;   // 2
        logic       par_odd;    // 1
        logic       par_en;     // 0
    } tx_ctrl_t;

    localparam logic [1:0] MODE_STD  = 2'b00;
    localparam logic [1:0] SEL_DATA  = 2'd0;
    localparam logic [1:0] SEL_PULSE = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

endpackage

// File: rtl/uptx_hold.sv
module uptx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] din,
    input  logic              pulse_busy,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] dout,
    output logic              pre
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            dout <= '0;
            pre  <= 1'b0;
        end else begin
            if (take) begin
                full <= 1'b0;
            end
            if (wr && (!full || take)) begin
                full <= 1'b1;
                dout <= din;
                // a word loaded before any pulse was queued goes ahead of it
                pre  <= !pulse_busy;
            end
        end
    end

endmodule

// File: rtl/uptx_pulse_q.sv
module uptx_pulse_q #(
    parameter int PLEN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [PLEN_W-1:0] cmd_len,
    input  logic              cmd_lvl,
    input  logic              mode_std,
    input  logic              inv,
    input  logic              active,
    input  logic              start,
    output logic              pend,
    output logic [PLEN_W-1:0] len,
    output logic              level
);

    logic accept;

    assign accept = cmd_wr && mode_std && !pend && !active && (cmd_len != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            len   <= '0;
            level <= 1'b1;
        end else begin
            if (start) begin
                pend <= 1'b0;
            end
            if (accept) begin
                pend  <= 1'b1;
                len   <= cmd_len;
                level <= cmd_lvl ^ inv;
            end
        end
    end

endmodule

// File: rtl/uptx_engine.sv
module uptx_engine
    import uptx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PLEN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              addr_en,
    input  logic              addr_val,
    input  logic              hold_full,
    input  logic              hold_pre,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              pend,
    input  logic [PLEN_W-1:0] plen,
    input  logic              plevel,
    output logic              take,
    output logic              pstart,
    output logic              active,
    output logic              eng_idle,
    output logic              txd
);

    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);
    localparam logic [PLEN_W-1:0] PULSE_LAST = PLEN_W'(1);

    tx_state_t         st, nxt;
    logic [DATA_W-1:0] shreg;
    logic [BW-1:0]     bcnt;
    logic              scnt;
    logic [PLEN_W-1:0] pcnt;
    logic              par;
    logic              load;
    logic              hold_go;

    assign hold_go = hold_full && (!pend || hold_pre);

    // next state and strobes
    always_comb begin
        nxt    = st;
        take   = 1'b0;
        load   = 1'b0;
        pstart = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (hold_go) begin
                    nxt  = S_ARMED;
                    take = 1'b1;
                    load = 1'b1;
                end else if (pend && tick) begin
                    nxt    = S_PULSE;
                    pstart = 1'b1;
                end
            end
            S_ARMED:  if (tick) nxt = S_START;
            S_START:  if (tick) nxt = S_DATA;
            S_DATA: begin
                if (tick && bcnt == LAST_BIT) begin
                    if (addr_en)     nxt = S_ADDR;
                    else if (par_en) nxt = S_PARITY;
                    else             nxt = S_STOP;
                end
            end
            S_ADDR:   if (tick) nxt = par_en ? S_PARITY : S_STOP;
            S_PARITY: if (tick) nxt = S_STOP;
            S_STOP: begin
                if (tick && scnt == two_stop) begin
                    if (hold_go) begin
                        nxt  = S_START;
                        take = 1'b1;
                        load = 1'b1;
                    end else if (pend) begin
                        nxt    = S_PULSE;
                        pstart = 1'b1;
                    end else begin
                        nxt = S_IDLE;
                    end
                end
            end
            S_PULSE: begin
                if (tick && pcnt == PULSE_LAST) begin
                    if (hold_full) begin
                        nxt  = S_START;
                        take = 1'b1;
                        load = 1'b1;
                    end else begin
                        nxt = S_IDLE;
                    end
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // shifter, counters and parity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            bcnt  <= '0;
            scnt  <= 1'b0;
            pcnt  <= '0;
            par   <= 1'b0;
        end else begin
            if (load) begin
                shreg <= hold_data;
                par   <= (^hold_data) ^ (addr_en & addr_val) ^ par_odd;
            end
            if (tick && st == S_START) begin
                bcnt <= '0;
            end
            if (tick && st == S_DATA) begin
                shreg <= shreg >> 1;
                bcnt  <= bcnt + 1'b1;
            end
            if (nxt == S_STOP && st != S_STOP) begin
                scnt <= 1'b0;
            end else if (tick && st == S_STOP) begin
                scnt <= 1'b1;
            end
            if (pstart) begin
                pcnt <= plen;
            end else if (tick && st == S_PULSE) begin
                pcnt <= pcnt - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            S_START:  txd = 1'b0;
            S_DATA:   txd = shreg[0];
            S_ADDR:   txd = addr_val;
            S_PARITY: txd = par;
            S_PULSE:  txd = plevel;
            default:  txd = 1'b1;
        endcase
        active   = (st == S_PULSE);
        eng_idle = (st == S_IDLE);
    end

endmodule

// File: rtl/uart_pulse_tx.sv
module uart_pulse_tx
    import uptx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PLEN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_idle
);

    tx_ctrl_t          ctrl_q;
    logic              mode_std;
    logic [PLEN_W-1:0] cmd_len;
    logic              cmd_lvl;
    logic              hold_full, hold_pre, take;
    logic [DATA_W-1:0] hold_data;
    logic              pend, plevel, pstart, active, eng_idle;
    logic [PLEN_W-1:0] plen;

    assign mode_std = (ctrl_q.mode == MODE_STD);
    assign cmd_len  = wr_data[PLEN_W-1:0];
    assign cmd_lvl  = wr_data[PLEN_W];

    always_ff @(posedge clk) begin
        if (!rst_n)                            ctrl_q <= '0;
        else if (wr_en && wr_sel == SEL_CTRL)  ctrl_q <= tx_ctrl_t'(wr_data[7:0]);
    end

    uptx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr_en && wr_sel == SEL_DATA),
        .din        (wr_data),
        .pulse_busy (pend || active),
        .take       (take),
        .full       (hold_full),
        .dout       (hold_data),
        .pre        (hold_pre)
    );

    uptx_pulse_q #(.PLEN_W(PLEN_W)) u_pq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (wr_en && wr_sel == SEL_PULSE),
        .cmd_len  (cmd_len),
        .cmd_lvl  (cmd_lvl),
        .mode_std (mode_std),
        .inv      (ctrl_q.pulse_inv),
        .active   (active),
        .start    (pstart),
        .pend     (pend),
        .len      (plen),
        .level    (plevel)
    );

    uptx_engine #(.DATA_W(DATA_W), .PLEN_W(PLEN_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .par_en    (ctrl_q.par_en),
        .par_odd   (ctrl_q.par_odd),
        .two_stop  (ctrl_q.two_stop),
        .addr_en   (ctrl_q.addr_en),
        .addr_val  (ctrl_q.addr_val),
        .hold_full (hold_full),
        .hold_pre  (hold_pre),
        .hold_data (hold_data),
        .pend      (pend),
        .plen      (plen),
        .plevel    (plevel),
        .take      (take),
        .pstart    (pstart),
        .active    (active),
        .eng_idle  (eng_idle),
        .txd       (txd)
    );

    assign hold_empty = !hold_full;
    assign tx_idle    = eng_idle && !pend && !hold_full;

endmodule

// File: rtl/uptx_checker.sv
module uptx_checker
    import uptx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PLEN_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [PLEN_W-1:0] cmd_len,
    input logic              mode_std,
    input logic              txd,
    input logic              hold_empty,
    input logic              tx_idle
);

    // R12
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> txd);

    // R1
    data_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_DATA && tx_idle) |=> !tx_idle ##1 hold_empty);

    // R2
    bit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(txd));

    // R8
    mode_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PULSE && !mode_std && tx_idle) |=> tx_idle);

    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PULSE && cmd_len == '0 && tx_idle) |=> tx_idle);

    // R11
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PULSE && mode_std && cmd_len != '0 && tx_idle)
        |=> !tx_idle);

endmodule

bind uart_pulse_tx uptx_checker #(.DATA_W(DATA_W), .PLEN_W(PLEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .cmd_len    (cmd_len),
    .mode_std   (mode_std),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_idle    (tx_idle)
);

// File: tb/uart_pulse_tx_test.sv
module uart_pulse_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = 8'h00;
    logic       txd, hold_empty, tx_idle;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tc = 0;
    int lidx = 0;
    logic bitlog [0:2047];

    uart_pulse_tx uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .txd(txd), .hold_empty(hold_empty), .tx_idle(tx_idle)
    );

    always #2 clk = ~clk;

    // tick every 8 clocks; log the line mid bit-time
    always @(negedge clk) begin
        if (!rst_n) begin
            tc   = 0;
            tick = 1'b0;
        end else begin
            tc   = (tc + 1) % 8;
            tick = (tc == 0);
            if (tc == 4 && lidx < 2048) begin
                bitlog[lidx] = txd;
                lidx++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected < 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && !tx_idle; i++) @(negedge clk);
        repeat (80) @(negedge clk);
    endtask

    function automatic logic [15:0] mkf(input logic [7:0] d, input logic [7:0] c, output int n);
        logic [15:0] b;
        int k;
        b = '0;
        b[0] = 1'b0;
        for (int i = 0; i < 8; i++) b[1+i] = d[i];
        k = 9;
        if (c[3]) begin b[k] = c[4]; k++; end
        if (c[0]) begin b[k] = (^d) ^ (c[3] & c[4]) ^ c[1]; k++; end
        b[k] = 1'b1; k++;
        if (c[2]) begin b[k] = 1'b1; k++; end
        n = k;
        return b;
    endfunction

    task automatic expect_stream(input int from, input logic [63:0] exp, input int n, input string tag);
        int s;
        logic [63:0] act, mask;
        s = -1;
        for (int i = from; i < lidx; i++) begin
            if (bitlog[i] == 1'b0) begin s = i; break; end
        end
        act = '1;
        if (s >= 0) for (int k = 0; k < n; k++) act[k] = (s + k < lidx) ? bitlog[s+k] : 1'bx;
        mask = (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
        check((s >= 0) && ((act & mask) === (exp & mask)), tag, act & mask, exp & mask);
    endtask

    task automatic t_reset();
        check(txd === 1'b1, "R12 txd", {63'd0, txd}, 64'd1);
        check(hold_empty === 1'b1, "R12 hold_empty", {63'd0, hold_empty}, 64'd1);
        check(tx_idle === 1'b1, "R12 tx_idle", {63'd0, tx_idle}, 64'd1);
    endtask

    task automatic t_basic();
        int m, n;
        logic [15:0] f;
        wr(2'd2, 8'h00);
        m = lidx;
        wr(2'd0, 8'hA5);
        @(negedge clk);
        check(hold_empty === 1'b1 && tx_idle === 1'b0, "R1 moved to shifter",
              {62'd0, hold_empty, tx_idle}, 64'd2);
        wait_idle();
        f = mkf(8'hA5, 8'h00, n);
        expect_stream(m, {48'd0, f}, n, "R2 8N1 frame");
    endtask

    task automatic t_b2b();
        int m, n1, n2;
        logic [15:0] f1, f2;
        m = lidx;
        wr(2'd0, 8'h3C);
        wr(2'd0, 8'hC3);
        check(hold_empty === 1'b0, "R1 second word held", {63'd0, hold_empty}, 64'd0);
        wait_idle();
        f1 = mkf(8'h3C, 8'h00, n1);
        f2 = mkf(8'hC3, 8'h00, n2);
        expect_stream(m, {48'd0, f1} | ({48'd0, f2} << n1), n1 + n2, "R1 back to back");
    endtask

    task automatic t_parity();
        int m, n;
        logic [15:0] f;
        wr(2'd2, 8'h07);
        m = lidx;
        wr(2'd0, 8'h07);
        wait_idle();
        f = mkf(8'h07, 8'h07, n);
        expect_stream(m, {48'd0, f}, n, "R3 odd parity two stop (R2)");
        wr(2'd2, 8'h01);
        m = lidx;
        wr(2'd0, 8'h03);
        wait_idle();
        f = mkf(8'h03, 8'h01, n);
        expect_stream(m, {48'd0, f}, n, "R3 even parity");
    endtask

    task automatic t_addr();
        int m, n;
        logic [15:0] f;
        wr(2'd2, 8'h19);
        m = lidx;
        wr(2'd0, 8'h01);
        wait_idle();
        f = mkf(8'h01, 8'h19, n);
        expect_stream(m, {48'd0, f}, n, "R4 address bit in parity");
        wr(2'd2, 8'h00);
    endtask

    task automatic t_break();
        int m, n1, n2;
        logic [15:0] f1, f2;
        logic [63:0] e;
        m = lidx;
        wr(2'd0, 8'h55);
        wr(2'd0, 8'hAA);
        wr(2'd1, 8'h0D);
        check(tx_idle === 1'b0, "R11 busy after command", {63'd0, tx_idle}, 64'd0);
        repeat (8 * 24) @(negedge clk);
        check(tx_idle === 1'b0, "R11 busy during pulse", {63'd0, tx_idle}, 64'd0);
        wr(2'd1, 8'h05);
        wait_idle();
        f1 = mkf(8'h55, 8'h00, n1);
        f2 = mkf(8'hAA, 8'h00, n2);
        e = {48'd0, f1} | ({48'd0, f2} << n1);
        e = e | (64'h7F << (n1 + n2 + 13));
        expect_stream(m, e, n1 + n2 + 20, "R5 R6 R11 break after queued words");
    endtask

    task automatic t_high();
        int m, n1, n2;
        logic [15:0] f1, f2;
        logic [63:0] e;
        m = lidx;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h85);
        wr(2'd0, 8'hFF);
        check(hold_empty === 1'b0, "R10 word held behind pulse", {63'd0, hold_empty}, 64'd0);
        wait_idle();
        f1 = mkf(8'h00, 8'h00, n1);
        f2 = mkf(8'hFF, 8'h00, n2);
        e = {48'd0, f1} | (64'h1F << n1) | ({48'd0, f2} << (n1 + 5));
        expect_stream(m, e, n1 + 5 + n2, "R10 R5 high pulse then word");
    endtask

    task automatic t_inv();
        int m, n;
        logic [15:0] f;
        logic [63:0] e;
        wr(2'd2, 8'h80);
        m = lidx;
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h83);
        wait_idle();
        f = mkf(8'hFF, 8'h00, n);
        e = {48'd0, f} | (64'hF << (n + 3));
        expect_stream(m, e, n + 7, "R7 inverted pulse low");
        wr(2'd2, 8'h00);
    endtask

    task automatic t_mode();
        int m;
        logic all1;
        wr(2'd2, 8'h20);
        m = lidx;
        wr(2'd1, 8'h0D);
        @(negedge clk);
        check(tx_idle === 1'b1, "R8 command ignored idle", {63'd0, tx_idle}, 64'd1);
        repeat (8 * 20) @(negedge clk);
        all1 = 1'b1;
        for (int i = m; i < lidx; i++) all1 &= bitlog[i];
        check(all1 === 1'b1, "R8 line stays high", {63'd0, all1}, 64'd1);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_zero();
        int m;
        logic all1;
        m = lidx;
        wr(2'd1, 8'h00);
        check(tx_idle === 1'b1, "R9 zero length idle", {63'd0, tx_idle}, 64'd1);
        repeat (8 * 6) @(negedge clk);
        all1 = tx_idle;
        for (int i = m; i < lidx; i++) all1 &= bitlog[i];
        check(all1 === 1'b1, "R9 zero length no line change", {63'd0, all1}, 64'd1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_b2b();
        t_parity();
        t_addr();
        t_break();
        t_high();
        t_inv();
        t_mode();
        t_zero();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule